// File: doc/BRIEF.md
# Countdown Event Timer

This block is a single-channel down-counting event timer. Software controls it through two word registers on a simple synchronous bus. The control word sits at offset 0x40 and the timeout word at offset 0x44. To arm the timer, software first sets the enable bit and then writes a tick count to the timeout word. That write starts the countdown, and no separate start bit is needed. When the count runs out, the timer raises a pending flag. An interrupt line shows that flag while interrupt delivery is turned on.

The enable bit gates everything. While it is low, the counter does not move, timeout writes are dropped, and the pending flag cannot change. A pending event is cleared by a control write that sets both the enable bit and the clear bit. The bus reads status back one cycle after a read request.

Top module: `countdown_timer`

## Requirements
- R1: After synchronous reset, and until the first write, the control readback is 0, the timeout readback is 0 and `irq` is 0.
- R2: A control write (address 0x40) stores bit 0 as enable and bit 1 as interrupt enable. The control readback returns enable at bit 0, interrupt enable at bit 1, the pending flag at bit 2 and the running state at bit 3. Bit 4 and every higher bit read 0.
- R3: A timeout write (address 0x44) while enable is low is dropped: the count and the running state stay as they were.
- R4: A timeout write of N while enable is high loads N and sets running. The count drops by one per cycle. The pending flag is set on the (N+1)th clock edge after the write edge. At that edge running clears and the count stays at 0.
- R5: A control write with bit 0 low stops the countdown at once. The count is frozen and running reads 0.
- R6: `irq` is registered and, in every cycle, equals pending AND interrupt enable.
- R7: A control write with bits 0 and 4 both set clears the pending flag. With bit 0 low, bit 4 leaves the flag unchanged.
- R8: If an expiry and a clearing control write fall on the same edge, the pending flag ends up set.
- R9: A timeout write while running reloads the count and restarts the countdown. A read of 0x44 returns the current count. Read data is registered, appears one cycle after `rd_en` and holds otherwise. Any other address reads 0.
- R10: The full 32-bit range is accepted: a load of 0xFFFFFFFF is counted down from that value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for `addr`/`wdata` |
| rd_en | input | 1 | Read strobe for `addr` |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Registered read data |
| irq | output | 1 | Registered interrupt output |

## Verification
The bench builds the block with its default parameters: a 32-bit counter, an 8-bit address and the offsets 0x40 and 0x44.

With the full counter width, the bench can load the 0xFFFFFFFF boundary and read it back while it counts, but it never waits for such a count to expire. Short loads of 2 to 5 ticks bring expiry within reach. That lets the bench count the exact expiry edge, collide an expiry with a clear, and reload a running timer. The behavioural model is compared against `irq` and `rdata` on every cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // bit positions in the control word (write and readback)
  localparam int unsigned B_EN   = 0;
  localparam int unsigned B_IE   = 1;
  localparam int unsigned B_PEND = 2;
  localparam int unsigned B_RUN  = 3;
  localparam int unsigned B_CLR  = 4;
endpackage

// File: rtl/tmr_ctrl_regs.sv
module tmr_ctrl_regs (
  input  logic clk,
  input  logic rst,
  input  logic ctrl_wr,
  input  logic en_wr,
  input  logic ie_wr,
  output logic en_q,
  output logic ie_q,
  output logic ie_d
);
  // next interrupt-enable value, used to register irq in step with state
  always_comb ie_d = ctrl_wr ? ie_wr : ie_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0;
      ie_q <= 1'b0;
    end else if (ctrl_wr) begin
      en_q <= en_wr;
      ie_q <= ie_wr;
    end
  end
endmodule

// File: rtl/tmr_down_counter.sv
module tmr_down_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_q,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             stop,
  output logic [CNT_W-1:0] cnt_q,
  output logic             run_q,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  always_comb expire = run_q && en_q && (cnt_q == ZERO);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= ZERO;
      run_q <= 1'b0;
    end else if (stop) begin
      run_q <= 1'b0;            // count is frozen where it stands
    end else if (load) begin
      cnt_q <= load_val;
      run_q <= 1'b1;
    end else if (expire) begin
      run_q <= 1'b0;
    end else if (run_q && en_q) begin
      cnt_q <= cnt_q - ONE;
    end
  end
endmodule

// File: rtl/tmr_pend_flag.sv
module tmr_pend_flag (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic clr,
  input  logic ie_d,
  output logic pend_q,
  output logic irq_q
);
  logic pend_d;

  // an expiry on the same edge as a clear wins: no event is lost
  always_comb begin
    pend_d = pend_q;
    if (clr)    pend_d = 1'b0;
    if (expire) pend_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      irq_q  <= pend_d && ie_d;
    end
  end
endmodule

// File: rtl/countdown_timer.sv
module countdown_timer #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned CNT_W    = 32,
  parameter logic [7:0]  CTRL_OFS = 8'h40,
  parameter logic [7:0]  VAL_OFS  = 8'h44
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              irq
);
  import tmr_pkg::*;

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] A_VAL  = ADDR_W'(VAL_OFS);

  logic             ctrl_wr, val_wr, en_q, ie_q, ie_d;
  logic             run_q, expire, pend_q, clr;
  logic [CNT_W-1:0] cnt_q, ctrl_rb;

  always_comb begin
    ctrl_wr = wr_en && (addr == A_CTRL);
    val_wr  = wr_en && (addr == A_VAL);
    clr     = ctrl_wr && wdata[B_EN] && wdata[B_CLR];
  end

  tmr_ctrl_regs u_regs (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr),
    .en_wr(wdata[B_EN]), .ie_wr(wdata[B_IE]),
    .en_q(en_q), .ie_q(ie_q), .ie_d(ie_d)
  );

  tmr_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en_q(en_q),
    .load(val_wr && en_q), .load_val(wdata),
    .stop(ctrl_wr && !wdata[B_EN]),
    .cnt_q(cnt_q), .run_q(run_q), .expire(expire)
  );

  tmr_pend_flag u_flag (
    .clk(clk), .rst(rst), .expire(expire), .clr(clr),
    .ie_d(ie_d), .pend_q(pend_q), .irq_q(irq)
  );

  always_comb begin
    ctrl_rb         = '0;
    ctrl_rb[B_EN]   = en_q;
    ctrl_rb[B_IE]   = ie_q;
    ctrl_rb[B_PEND] = pend_q;
    ctrl_rb[B_RUN]  = run_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      if (addr == A_CTRL)     rdata <= ctrl_rb;
      else if (addr == A_VAL) rdata <= cnt_q;
      else                    rdata <= '0;
    end
  end
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned CNT_W    = 32,
  parameter logic [7:0]  CTRL_OFS = 8'h40,
  parameter logic [7:0]  VAL_OFS  = 8'h44
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [CNT_W-1:0]  wdata,
  input logic              irq,
  input logic              en_q,
  input logic              ie_q,
  input logic              pend_q,
  input logic              run_q,
  input logic [CNT_W-1:0]  cnt_q
);
  logic wc, wv, ex;
  always_comb begin
    wc = wr_en && (addr == ADDR_W'(CTRL_OFS));
    wv = wr_en && (addr == ADDR_W'(VAL_OFS));
    ex = run_q && en_q && (cnt_q == '0);
  end

  p_val_ignored_r3: assert property (@(posedge clk) disable iff (rst)
    (wv && !en_q) |=> ($stable(cnt_q) && $stable(run_q)));

  p_expire_sets_r4: assert property (@(posedge clk) disable iff (rst)
    (ex && !wc) |=> (pend_q && !run_q));

  p_stop_r5: assert property (@(posedge clk) disable iff (rst)
    (wc && !wdata[0]) |=> !run_q);

  p_run_needs_en_r5: assert property (@(posedge clk) disable iff (rst)
    run_q |-> en_q);

  p_irq_gate_r6: assert property (@(posedge clk) disable iff (rst)
    irq == (pend_q && ie_q));

  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (wc && wdata[0] && wdata[4] && !ex) |=> !pend_q);

  p_noclear_r7: assert property (@(posedge clk) disable iff (rst)
    (wc && !wdata[0] && !ex) |=> $stable(pend_q));

  p_collide_r8: assert property (@(posedge clk) disable iff (rst)
    (ex && wc && wdata[0] && wdata[4]) |=> pend_q);
endmodule

bind countdown_timer tmr_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .CTRL_OFS(CTRL_OFS), .VAL_OFS(VAL_OFS)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .irq(irq), .en_q(en_q), .ie_q(ie_q), .pend_q(pend_q), .run_q(run_q),
  .cnt_q(cnt_q)
);

// File: tb/sim_countdown_timer.sv
`timescale 1ns/1ps
module sim_countdown_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata;
  logic        irq;

  int tests = 0, fails = 0;
  bit done = 1'b0, cmp_on = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  countdown_timer u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // behavioural reference, updated on every rising edge
  bit m_en = 0, m_ie = 0, m_pend = 0, m_run = 0, m_irq = 0;
  logic [31:0] m_cnt = 0, m_rdata = 0;
  bit e, wc, wv, np, ni;

  always @(posedge clk) begin
    if (rst) begin
      m_en <= 0; m_ie <= 0; m_pend <= 0; m_run <= 0; m_irq <= 0;
      m_cnt <= 0; m_rdata <= 0;
    end else begin
      e  = m_run && m_en && (m_cnt == 0);
      wc = wr_en && addr == 8'h40;
      wv = wr_en && addr == 8'h44;
      np = m_pend;
      if (wc && wdata[0] && wdata[4]) np = 0;
      if (e) np = 1;
      ni = wc ? wdata[1] : m_ie;
      m_pend <= np;
      m_ie   <= ni;
      m_irq  <= np && ni;
      if (wc) m_en <= wdata[0];
      if (wc && !wdata[0]) m_run <= 0;
      else if (wv && m_en) begin m_cnt <= wdata; m_run <= 1; end
      else if (e) m_run <= 0;
      else if (m_run && m_en) m_cnt <= m_cnt - 1;
      if (rd_en) begin
        if (addr == 8'h40) m_rdata <= {28'h0, m_run, m_pend, m_ie, m_en};
        else if (addr == 8'h44) m_rdata <= m_cnt;
        else m_rdata <= 0;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      check("R6 irq vs model", {31'h0, irq}, {31'h0, m_irq});
      check("R9 rdata vs model", rdata, m_rdata);
    end
  end

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    tick();
    wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    rd_en = 1; addr = a;
    tick();
    rd_en = 0;
    check(tag, rdata, exp);
  endtask

  initial begin
    @(negedge clk); tick(); tick();
    rst = 0; cmp_on = 1;
    check("R1 irq after reset", {31'h0, irq}, 32'h0);
    rd(8'h40, 32'h0, "R1 ctrl after reset");
    rd(8'h44, 32'h0, "R1 value after reset");

    wr(8'h44, 32'd10);                         // enable low: dropped
    rd(8'h40, 32'h0, "R3 not running");
    rd(8'h44, 32'h0, "R3 value unchanged");

    wr(8'h40, 32'h13);
    rd(8'h40, 32'h3, "R2 ctrl readback, bit4 zero");

    wr(8'h44, 32'd5);                          // load at edge k
    for (int i = 0; i < 5; i++) tick();
    check("R4 no expiry before N+1", {31'h0, irq}, 32'h0);
    tick();
    check("R4 expiry at N+1 / R6 irq", {31'h0, irq}, 32'h1);
    rd(8'h40, 32'h7, "R4 pending set, running clear");
    rd(8'h44, 32'h0, "R4 count stays 0");

    wr(8'h40, 32'h01);
    check("R6 irq masked", {31'h0, irq}, 32'h0);
    rd(8'h40, 32'h5, "R6 pending kept while masked");
    wr(8'h40, 32'h10);
    rd(8'h40, 32'h4, "R7 clear ignored with enable low");
    wr(8'h40, 32'h13);
    rd(8'h40, 32'h3, "R7 clear with enable");
    check("R7 irq low after clear", {31'h0, irq}, 32'h0);

    wr(8'h44, 32'd100);
    for (int i = 0; i < 3; i++) tick();
    wr(8'h40, 32'h00);
    rd(8'h44, 32'd97, "R5 count frozen on stop");
    for (int i = 0; i < 5; i++) tick();
    rd(8'h44, 32'd97, "R5 still frozen");
    rd(8'h40, 32'h0, "R5 stopped");

    wr(8'h40, 32'h03);
    wr(8'h44, 32'd50);
    tick(); tick();
    wr(8'h44, 32'd3);                          // reload while running
    for (int i = 0; i < 3; i++) tick();
    check("R9 reload, no early expiry", {31'h0, irq}, 32'h0);
    tick();
    check("R9 reload expiry", {31'h0, irq}, 32'h1);

    wr(8'h40, 32'h13);
    wr(8'h44, 32'd2);
    tick(); tick();
    wr(8'h40, 32'h13);                         // collides with expiry
    rd(8'h40, 32'h7, "R8 expiry wins over clear");

    wr(8'h40, 32'h13);
    wr(8'h44, 32'hFFFF_FFFF);
    tick();
    rd(8'h44, 32'hFFFF_FFFE, "R10 full-range load counts");
    rd(8'h40, 32'hB, "R10 running");
    rd(8'h48, 32'h0, "R9 unmapped reads zero");

    rst = 1; tick(); tick(); rst = 0;
    rd(8'h40, 32'h0, "R1 ctrl after mid-run reset");
    rd(8'h44, 32'h0, "R1 value after mid-run reset");
    check("R1 irq after mid-run reset", {31'h0, irq}, 32'h0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule